// File: doc/BRIEF.md
# Receive Packet Fault Sorter

This block sits behind the lane front end and header decoder of a camera serial receiver. For each incoming packet it takes the error flags the upstream logic raises: start-of-transmission soft error, start-of-transmission sync failure, ECC single-bit corrected, ECC double-bit, unsupported data identifier, CRC mismatch and word-count shortfall. It decides whether the packet is kept for processing or dropped. A dropped packet is skipped until the next header arrives.

Every condition is recorded in a sticky 32-bit status word. Writing 1 to a bit clears it. A set event in the same cycle as a clear write wins over the clear. The block also flags a lane configuration that asks for more active lanes than the maximum, and it flags the arrival of a frame end short packet. A mask register selects which status bits drive a registered interrupt line.

Top module: `pkt_fault_sorter`

## Requirements
- R1: A header with the sync-failure flag gives a drop decision (`decValid`=1, `decDrop`=1) one cycle after `hdrValid`, and sets status bit 12.
- R2: A header with the ECC double-bit flag gives a drop decision one cycle later and sets status bit 11.
- R3: A header with the unsupported data identifier flag gives a drop decision one cycle later and sets status bit 8.
- R4: A header whose only flags are soft error (bit 13) or ECC corrected (bit 10) gives a keep decision (`decDrop`=0) and sets those bits. A CRC mismatch at the end of a kept packet sets bit 9.
- R5: After a drop decision, `crcBad` and `shortWc` reported with `pktDone` for that packet leave bits 9 and 22 unchanged. If `hdrValid` and `pktDone` come in the same cycle, the header is taken and the end event is ignored.
- R6: `shortWc` reported with `pktDone` of a kept packet sets status bit 22.
- R7: Status bit 21 is set on every cycle in which `lanesActive` > `lanesMax`.
- R8: Only bits 31, 22, 21, 13, 12, 11, 10, 9 and 8 of `statusOut` can ever be 1. All other bits read 0, and writes to them are ignored.
- R9: A write with `regWrEn`=1 and `regAddr`=0 clears each status bit written as 1 on the next edge. Bits written as 0 keep their value.
- R10: A set event and a clear write to the same bit in the same cycle leave the bit at 1.
- R11: A `frameEnd` pulse sets status bit 31.
- R12: A write with `regAddr`=1 loads the 32-bit interrupt mask. `irq` equals the OR of (`statusOut` AND mask) as it stood one cycle earlier.
- R13: `decValid` is 1 exactly in the cycle after a `hdrValid` pulse, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Decoded header present this cycle |
| sotSoft | input | 1 | Start-of-transmission soft error for this header |
| sotSyncFail | input | 1 | Start-of-transmission sync failure for this header |
| eccFixed | input | 1 | Single-bit header error corrected |
| eccDouble | input | 1 | Double-bit header error detected |
| dataIdBad | input | 1 | Data identifier unrecognized or unimplemented |
| pktDone | input | 1 | Payload of current packet ended |
| crcBad | input | 1 | Payload CRC mismatch, qualified by pktDone |
| shortWc | input | 1 | Fewer bytes than word count, qualified by pktDone |
| frameEnd | input | 1 | Frame end short packet arrived |
| lanesActive | input | LANE_W | Configured active lane count |
| lanesMax | input | LANE_W | Maximum lane count |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register index: 0 status, 1 mask |
| regWrData | input | 32 | Register write data |
| statusOut | output | 32 | Sticky status word |
| decValid | output | 1 | Keep/drop decision valid |
| decDrop | output | 1 | 1 = packet dropped |
| irq | output | 1 | Registered interrupt |

## Verification
The bench targets a set event and a clear write landing on the same bit, which a design that lets the clear win would report as 0. It also checks that end-of-packet flags after a drop do not set CRC or word-count bits, since a design without a skip state would record faults for a discarded packet. A header and a packet end in the same cycle test the header-first ordering. Zero writes and writes to reserved bits catch a write port that loads data instead of clearing, and the one-cycle interrupt lag catches an unregistered or mis-masked `irq`.

// File: rtl/pkt_fault_pkg.sv
package pkt_fault_pkg;
  localparam int STAT_W    = 32;
  localparam int BIT_FRAME = 31;
  localparam int BIT_WC    = 22;
  localparam int BIT_LANE  = 21;
  localparam int BIT_SOT   = 13;
  localparam int BIT_SYNC  = 12;
  localparam int BIT_ECC2  = 11;
  localparam int BIT_ECC1  = 10;
  localparam int BIT_CRC   = 9;
  localparam int BIT_ID    = 8;

  typedef enum logic [1:0] {
    PKT_IDLE = 2'd0,
    PKT_LIVE = 2'd1,
    PKT_SKIP = 2'd2
  } pktPhase_e;

  typedef struct packed {
    logic frameEnd;
    logic wcShort;
    logic laneBad;
    logic sotSoft;
    logic sotSync;
    logic eccDbl;
    logic eccFix;
    logic crcBad;
    logic idBad;
  } setStrobe_t;

  function automatic logic [STAT_W-1:0] implMask();
    logic [STAT_W-1:0] m;
    m = '0;
    m[BIT_FRAME] = 1'b1;
    m[BIT_WC]    = 1'b1;
    m[BIT_LANE]  = 1'b1;
    m[BIT_SOT]   = 1'b1;
    m[BIT_SYNC]  = 1'b1;
    m[BIT_ECC2]  = 1'b1;
    m[BIT_ECC1]  = 1'b1;
    m[BIT_CRC]   = 1'b1;
    m[BIT_ID]    = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pkt_fault_ctrl.sv
module pkt_fault_ctrl
  import pkt_fault_pkg::*;
#(
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic              sotSoft,
  input  logic              sotSyncFail,
  input  logic              eccFixed,
  input  logic              eccDouble,
  input  logic              dataIdBad,
  input  logic              pktDone,
  input  logic              crcBad,
  input  logic              shortWc,
  input  logic              frameEnd,
  input  logic [LANE_W-1:0] lanesActive,
  input  logic [LANE_W-1:0] lanesMax,
  output setStrobe_t        setStb,
  output logic              decValid,
  output logic              decDrop
);
  pktPhase_e phaseQ, phaseD;
  logic      dropNow;
  logic      endLive;

  // Drop classes: payload end unknown or unusable.
  assign dropNow = sotSyncFail | eccDouble | dataIdBad;
  // Header has priority over a coincident end event.
  assign endLive = pktDone & !hdrValid & (phaseQ == PKT_LIVE);

  always_comb begin
    phaseD = phaseQ;
    if (hdrValid) begin
      phaseD = dropNow ? PKT_SKIP : PKT_LIVE;
    end else if (pktDone) begin
      phaseD = PKT_IDLE;
    end
  end

  always_comb begin
    setStb          = '0;
    setStb.frameEnd = frameEnd;
    setStb.laneBad  = lanesActive > lanesMax;
    setStb.sotSoft  = hdrValid & sotSoft;
    setStb.sotSync  = hdrValid & sotSyncFail;
    setStb.eccDbl   = hdrValid & eccDouble;
    setStb.eccFix   = hdrValid & eccFixed;
    setStb.idBad    = hdrValid & dataIdBad;
    setStb.crcBad   = endLive & crcBad;
    setStb.wcShort  = endLive & shortWc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= PKT_IDLE;
      decValid <= 1'b0;
      decDrop  <= 1'b0;
    end else begin
      phaseQ   <= phaseD;
      decValid <= hdrValid;
      decDrop  <= hdrValid & dropNow;
    end
  end

  assert_drop_sync_R1: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && sotSyncFail |=> decValid && decDrop);
  assert_drop_ecc_R2: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && eccDouble |=> decValid && decDrop);
  assert_drop_id_R3: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && dataIdBad |=> decDrop);
  assert_keep_soft_R4: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && !sotSyncFail && !eccDouble && !dataIdBad |=> decValid && !decDrop);
  assert_skip_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    decValid && decDrop && pktDone && !hdrValid |-> !setStb.crcBad && !setStb.wcShort);
  assert_dec_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !decValid);
endmodule

// File: rtl/pkt_fault_regs.sv
module pkt_fault_regs
  import pkt_fault_pkg::*;
#(
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  setStrobe_t        setStb,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [STAT_W-1:0] regWrData,
  output logic [STAT_W-1:0] statusQ,
  output logic              irq
);
  localparam logic [STAT_W-1:0] IMPL      = implMask();
  localparam logic [REG_AW-1:0] ADDR_STAT = REG_AW'(0);
  localparam logic [REG_AW-1:0] ADDR_MASK = REG_AW'(1);

  logic [STAT_W-1:0] setVec, clrVec, statusD, maskQ;

  always_comb begin
    setVec            = '0;
    setVec[BIT_FRAME] = setStb.frameEnd;
    setVec[BIT_WC]    = setStb.wcShort;
    setVec[BIT_LANE]  = setStb.laneBad;
    setVec[BIT_SOT]   = setStb.sotSoft;
    setVec[BIT_SYNC]  = setStb.sotSync;
    setVec[BIT_ECC2]  = setStb.eccDbl;
    setVec[BIT_ECC1]  = setStb.eccFix;
    setVec[BIT_CRC]   = setStb.crcBad;
    setVec[BIT_ID]    = setStb.idBad;
  end

  assign clrVec  = (regWrEn && regAddr == ADDR_STAT) ? (regWrData & IMPL) : '0;
  // Set applied after clear so a coincident set survives.
  assign statusD = (statusQ & ~clrVec) | setVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      irq     <= 1'b0;
    end else begin
      statusQ <= statusD & IMPL;
      if (regWrEn && regAddr == ADDR_MASK) maskQ <= regWrData;
      irq     <= |(statusQ & maskQ);
    end
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((statusQ & $past(setVec)) == $past(setVec)));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_STAT && setVec == '0
    |=> (statusQ & $past(regWrData)) == '0);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
endmodule

// File: rtl/pkt_fault_sorter.sv
module pkt_fault_sorter
  import pkt_fault_pkg::*;
#(
  parameter int LANE_W = 3,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic              sotSoft,
  input  logic              sotSyncFail,
  input  logic              eccFixed,
  input  logic              eccDouble,
  input  logic              dataIdBad,
  input  logic              pktDone,
  input  logic              crcBad,
  input  logic              shortWc,
  input  logic              frameEnd,
  input  logic [LANE_W-1:0] lanesActive,
  input  logic [LANE_W-1:0] lanesMax,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       statusOut,
  output logic              decValid,
  output logic              decDrop,
  output logic              irq
);
  setStrobe_t setStb;

  pkt_fault_ctrl #(.LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .sotSoft(sotSoft),
    .sotSyncFail(sotSyncFail), .eccFixed(eccFixed), .eccDouble(eccDouble),
    .dataIdBad(dataIdBad), .pktDone(pktDone), .crcBad(crcBad),
    .shortWc(shortWc), .frameEnd(frameEnd), .lanesActive(lanesActive),
    .lanesMax(lanesMax), .setStb(setStb), .decValid(decValid), .decDrop(decDrop)
  );

  pkt_fault_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rstN(rstN), .setStb(setStb), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .statusQ(statusOut), .irq(irq)
  );

  assert_lane_cfg_R7: assert property (@(posedge clk) disable iff (!rstN)
    lanesActive > lanesMax |=> statusOut[BIT_LANE]);
  assert_frame_end_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> statusOut[BIT_FRAME]);
  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut & ~implMask()) == '0);
endmodule

// File: tb/test_pkt_fault_sorter.sv
module test_pkt_fault_sorter;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'h8060_3F00;

  logic clk = 0, rstN = 0;
  logic hdrValid = 0, sotSoft = 0, sotSyncFail = 0, eccFixed = 0, eccDouble = 0, dataIdBad = 0;
  logic pktDone = 0, crcBad = 0, shortWc = 0, frameEnd = 0;
  logic [2:0] lanesActive = 3'd2, lanesMax = 3'd4;
  logic regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] statusOut;
  logic decValid, decDrop, irq;

  int total = 0, bad = 0;
  logic [31:0] eStat = 0, eMask = 0;
  logic eIrq = 0, eDecV = 0, eDecD = 0;
  int ePhase = 0; // 0 idle, 1 live, 2 skip

  pkt_fault_sorter i_pkt_fault_sorter (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    hdrValid = 0; sotSoft = 0; sotSyncFail = 0; eccFixed = 0; eccDouble = 0; dataIdBad = 0;
    pktDone = 0; crcBad = 0; shortWc = 0; frameEnd = 0; regWrEn = 0; regWrData = 0; regAddr = 0;
  endtask

  // One clock with model update; optional full compare.
  task automatic step(input bit full);
    logic [31:0] setv, clr, nStat, nMask;
    logic nIrq, nDrop;
    int nPh;
    setv = 0; nPh = ePhase;
    nDrop = sotSyncFail | eccDouble | dataIdBad;
    if (hdrValid) begin
      setv[13] = sotSoft; setv[12] = sotSyncFail; setv[11] = eccDouble;
      setv[10] = eccFixed; setv[8] = dataIdBad;
      nPh = nDrop ? 2 : 1;
    end else if (pktDone) begin
      if (ePhase == 1) begin setv[9] = crcBad; setv[22] = shortWc; end
      nPh = 0;
    end
    setv[31] = frameEnd;
    setv[21] = lanesActive > lanesMax;
    clr = (regWrEn && regAddr == 0) ? regWrData : 0;
    nStat = ((eStat & ~clr) | setv) & IMPL;
    nMask = (regWrEn && regAddr == 1) ? regWrData : eMask;
    nIrq = |(eStat & eMask);
    eDecV = hdrValid; eDecD = hdrValid & nDrop;
    @(posedge clk); #1;
    eStat = nStat; eMask = nMask; eIrq = nIrq; ePhase = nPh;
    if (full) begin
      chk("R10 status", statusOut, eStat);
      chk("R12 irq", {31'b0, irq}, {31'b0, eIrq});
      chk("R13 decValid", {31'b0, decValid}, {31'b0, eDecV});
      if (eDecV) chk("R13 decDrop", {31'b0, decDrop}, {31'b0, eDecD});
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd9021));
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    chk("R8 reset status", statusOut, 32'h0);
    chk("R13 reset decValid", {31'b0, decValid}, 32'h0);

    // R1: sync failure drops
    quiet(); hdrValid = 1; sotSyncFail = 1; step(1);
    chk("R1 drop", {30'b0, decValid, decDrop}, 32'h3);
    chk("R1 bit12", {31'b0, statusOut[12]}, 32'h1);
    // R5: end flags of dropped packet ignored
    quiet(); pktDone = 1; crcBad = 1; shortWc = 1; step(1);
    chk("R5 skip crc/wc", {30'b0, statusOut[22], statusOut[9]}, 32'h0);

    // R2
    quiet(); hdrValid = 1; eccDouble = 1; step(1);
    chk("R2 drop", {30'b0, decValid, decDrop}, 32'h3);
    chk("R2 bit11", {31'b0, statusOut[11]}, 32'h1);
    // R3
    quiet(); hdrValid = 1; dataIdBad = 1; step(1);
    chk("R3 drop", {31'b0, decDrop}, 32'h1);
    chk("R3 bit8", {31'b0, statusOut[8]}, 32'h1);

    // R4 + R6: kept packet with soft flags, then CRC and short count
    quiet(); hdrValid = 1; sotSoft = 1; eccFixed = 1; step(1);
    chk("R4 keep", {30'b0, decValid, decDrop}, 32'h2);
    chk("R4 bits13/10", {30'b0, statusOut[13], statusOut[10]}, 32'h3);
    quiet(); pktDone = 1; crcBad = 1; shortWc = 1; step(1);
    chk("R4 crc bit9", {31'b0, statusOut[9]}, 32'h1);
    chk("R6 wc bit22", {31'b0, statusOut[22]}, 32'h1);

    // R9: clear all, zero-write no effect, reserved write ignored
    quiet(); wr(0, 32'hFFFF_FFFF); step(1);
    chk("R9 cleared", statusOut, 32'h0);
    quiet(); frameEnd = 1; step(1);
    chk("R11 bit31", statusOut, 32'h8000_0000);
    quiet(); wr(0, 32'h7FFF_FFFF); step(1);
    chk("R9 zero write keeps", statusOut, 32'h8000_0000);
    quiet(); wr(0, 32'h8000_0000); step(1);
    chk("R9 w1c", statusOut, 32'h0);
    chk("R8 reserved zero", statusOut & ~IMPL, 32'h0);

    // R10: set and clear together
    quiet(); frameEnd = 1; wr(0, 32'h8000_0000); step(1);
    chk("R10 set wins", {31'b0, statusOut[31]}, 32'h1);

    // R7: lane config
    quiet(); lanesActive = 3'd5; lanesMax = 3'd4; wr(0, 32'hFFFF_FFFF); step(1);
    chk("R7 lane bit21", {31'b0, statusOut[21]}, 32'h1);
    lanesActive = 3'd2; quiet(); wr(0, 32'hFFFF_FFFF); step(1);
    chk("R7 cleared once legal", statusOut, 32'h0);

    // R12: mask and irq lag
    quiet(); wr(1, 32'h0000_0200); step(1);
    quiet(); hdrValid = 1; step(1);
    quiet(); pktDone = 1; crcBad = 1; step(1);
    chk("R12 irq not yet", {31'b0, irq}, 32'h0);
    quiet(); step(1);
    chk("R12 irq up", {31'b0, irq}, 32'h1);

    // R5: header and end in same cycle -> header taken
    quiet(); wr(0, 32'hFFFF_FFFF); step(1);
    quiet(); hdrValid = 1; step(1);
    quiet(); hdrValid = 1; pktDone = 1; crcBad = 1; step(1);
    chk("R5 header first", {31'b0, statusOut[9]}, 32'h0);
    chk("R13 back-to-back", {31'b0, decValid}, 32'h1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      quiet();
      r = $urandom_range(0, 9);
      if (r < 3) begin
        hdrValid = 1;
        sotSoft = ($urandom_range(0, 3) == 0); sotSyncFail = ($urandom_range(0, 5) == 0);
        eccFixed = ($urandom_range(0, 3) == 0); eccDouble = ($urandom_range(0, 5) == 0);
        dataIdBad = ($urandom_range(0, 5) == 0);
      end
      if (r >= 2 && r < 5) begin
        pktDone = 1; crcBad = $urandom_range(0, 1); shortWc = $urandom_range(0, 1);
      end
      frameEnd = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) wr(2'($urandom_range(0, 2)), $urandom());
      lanesActive = 3'($urandom_range(1, 4));
      lanesMax = ($urandom_range(0, 19) == 0) ? 3'd1 : 3'd4;
      step(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule